// File: doc/BRIEF.md
# Virtual Compare Timer

This block is one core's deadline timer. A free-running 64-bit system count comes in from outside. The block subtracts a programmable 64-bit offset from it to form a virtual count. It holds a 64-bit deadline and raises a level-sensitive interrupt once the virtual count has reached that deadline, provided the timer is enabled and the interrupt is not masked.

Software can set the deadline in two ways. It can write an absolute 64-bit value. It can also write a relative distance from "now": the block takes only the low 32 bits of the written word, treats them as a two's-complement number and adds that number, sign-extended, to the current virtual count. A negative distance therefore lands in the past and the timer fires at once, even when the full 64-bit word would look like a large positive number.

Reading the relative register returns the remaining distance, cut to 32 bits, with the upper half zero. Register access is a plain port: the read data follows the address with no delay, and a write takes effect at the clock edge.

Top module: `gen_timer_cmp`

## Requirements
- R1: After synchronous active-low reset: enable, mask, deadline and offset are all zero. The control word reads 0 and `irq` is low.
- R2: The virtual count equals `sys_cnt` minus the offset, modulo 2^64. Reading address 2 returns the deadline minus the virtual count, truncated to 32 bits.
- R3: The firing condition is an unsigned 64-bit comparison: virtual count >= deadline. A deadline with bit 63 set stays in the future for a small virtual count.
- R4: A write to address 2 sets deadline = virtual count + sign-extend(data[31:0]). Data bits [63:32] have no effect on the result.
- R5: A write to address 2 whose bits [31:0] are negative, for example 0x1_FFFF_FFFF, puts the deadline in the past. The firing condition is then met at once.
- R6: A read of address 2 always returns zero in bits [63:32].
- R7: Control bit 2 (status) reads as the firing condition while enable is set, and reads as 0 while enable is clear. Writes to it have no effect.
- R8: `irq` is a registered level. One cycle after the inputs settle, it equals enable AND NOT mask AND condition.
- R9: A write to address 1 replaces all 64 deadline bits, and the new value reads back at address 1.
- R10: A write to address 3 replaces the offset, and it is used from the next cycle on. Without such a write the offset holds its value.
- R11: The register map is: 0 = control (bit 0 enable, bit 1 mask, bit 2 status, other bits read 0), 1 = deadline, 2 = relative value, 3 = offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_cnt | input | 64 | Free-running system count |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the selected register (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:
- the interrupt stays low whenever the timer was disabled or masked in the previous cycle, and rises after the firing condition held while enabled and unmasked;
- status is zero while disabled;
- the relative read has its upper half zero;
- the offset holds its value unless written;
- an absolute or relative deadline write lands exactly as specified.

Some behaviour only the bench scenarios can show, because it needs chosen count values: that a negative relative write fires at once while the same word read as a 64-bit number would not; that bit 63 of the deadline is compared unsigned; that an offset change moves the remaining distance; and that writing the status bit does nothing.

// File: rtl/tcu_pkg.sv
// Package: shared register addresses and control bit positions for the
// virtual compare timer. Assumes a four-word register space.
package tcu_pkg;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_CMP  = 2'd1,
        A_TVAL = 2'd2,
        A_OFF  = 2'd3
    } tcu_addr_e;

    localparam int CTL_EN   = 0;
    localparam int CTL_MASK = 1;
    localparam int CTL_STAT = 2;
    localparam int CTL_BITS = 3;

endpackage

// File: rtl/tcu_regs.sv
// Module: register state of the timer (enable, mask, deadline, offset).
// Decodes writes. A relative write sign-extends the low TVAL_W bits and
// adds them to the virtual count that is current at the write edge.
// Assumes a single write port and synchronous active-low reset.
module tcu_regs
    import tcu_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int TVAL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] vcnt,
    output logic             en_o,
    output logic             mask_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic [CNT_W-1:0] off_o
);
    localparam int EXT_W = CNT_W - TVAL_W;

    logic             en_q, mask_q;
    logic [CNT_W-1:0] cmp_q, off_q;
    logic [CNT_W-1:0] rel_sext;

    // Sign-extend the relative distance; the upper write bits are dropped.
    always_comb begin
        rel_sext = {{EXT_W{wr_data[TVAL_W-1]}}, wr_data[TVAL_W-1:0]};
    end

    // Register update on writes; the status bit has no storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= 1'b0;
            cmp_q  <= '0;
            off_q  <= '0;
        end else if (wr_en) begin
            case (tcu_addr_e'(addr))
                A_CTRL: begin
                    en_q   <= wr_data[CTL_EN];
                    mask_q <= wr_data[CTL_MASK];
                end
                A_CMP:   cmp_q <= wr_data;
                A_TVAL:  cmp_q <= vcnt + rel_sext;
                A_OFF:   off_q <= wr_data;
                default: ;
            endcase
        end
    end

    assign en_o   = en_q;
    assign mask_o = mask_q;
    assign cmp_o  = cmp_q;
    assign off_o  = off_q;

    // R9: an absolute write lands all 64 bits
    p_cmp_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CMP) |=> (cmp_q == $past(wr_data)));

    // R4: a relative write places the deadline at the signed distance
    p_tval_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_TVAL) |=>
            ((cmp_q - $past(vcnt)) ==
             {{EXT_W{$past(wr_data[TVAL_W-1])}}, $past(wr_data[TVAL_W-1:0])}));

    // R10: the offset holds unless it is written
    p_off_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_OFF) |=> $stable(off_q));

endmodule

// File: rtl/tcu_eval.sv
// Module: forms the virtual count and the remaining distance, evaluates
// the unsigned firing condition, and registers the interrupt level.
// Assumes sys_cnt is synchronous to clk.
module tcu_eval #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] sys_cnt,
    input  logic [CNT_W-1:0] off,
    input  logic [CNT_W-1:0] cmp,
    input  logic             en,
    input  logic             mask,
    output logic [CNT_W-1:0] vcnt_o,
    output logic [CNT_W-1:0] remain_o,
    output logic             status_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] vcnt;
    logic             cond;
    logic             irq_q;

    // Virtual count, remaining distance and the unsigned condition.
    always_comb begin
        vcnt     = sys_cnt - off;
        remain_o = cmp - vcnt;
        cond     = (vcnt >= cmp);
        status_o = en & cond;
    end

    // Registered interrupt level, free of glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= en & ~mask & cond;
    end

    assign vcnt_o = vcnt;
    assign irq_o  = irq_q;

    // R7: status reads zero while disabled
    p_status_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !status_o);

    // R8: a disabled timer leaves the interrupt low
    p_irq_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !irq_q);

    // R8: a masked timer leaves the interrupt low
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mask |=> !irq_q);

    // R3: an enabled, unmasked timer whose count reached the deadline fires
    p_irq_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mask && (vcnt >= cmp)) |=> irq_q);

endmodule

// File: rtl/tcu_rdmux.sv
// Module: read data selection. Builds the control word and returns the
// relative distance cut to TVAL_W bits with the upper bits zero.
// Assumes a combinational read with no side effects.
module tcu_rdmux
    import tcu_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int TVAL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             en,
    input  logic             mask,
    input  logic             status,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] off,
    input  logic [CNT_W-1:0] remain,
    output logic [CNT_W-1:0] rd_data
);
    localparam int EXT_W = CNT_W - TVAL_W;

    // Select the addressed register.
    always_comb begin
        case (tcu_addr_e'(addr))
            A_CTRL:  rd_data = {{(CNT_W-CTL_BITS){1'b0}}, status, mask, en};
            A_CMP:   rd_data = cmp;
            A_TVAL:  rd_data = {{EXT_W{1'b0}}, remain[TVAL_W-1:0]};
            A_OFF:   rd_data = off;
            default: rd_data = '0;
        endcase
    end

    // R6: the relative read has zero upper bits
    p_tval_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_TVAL) |-> (rd_data[CNT_W-1:TVAL_W] == '0));

endmodule

// File: rtl/gen_timer_cmp.sv
// Module: top of the virtual compare timer. Connects the register state,
// the evaluator and the read selection.
// Assumes one clock domain and synchronous active-low reset.
module gen_timer_cmp #(
    parameter int CNT_W  = 64,
    parameter int TVAL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] sys_cnt,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq
);
    logic             en, mask, status;
    logic [CNT_W-1:0] cmp, off, vcnt, remain;

    tcu_regs #(.CNT_W(CNT_W), .TVAL_W(TVAL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wr_data(reg_wdata), .vcnt(vcnt), .en_o(en), .mask_o(mask),
        .cmp_o(cmp), .off_o(off)
    );

    tcu_eval #(.CNT_W(CNT_W)) u_eval (
        .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .off(off), .cmp(cmp),
        .en(en), .mask(mask), .vcnt_o(vcnt), .remain_o(remain),
        .status_o(status), .irq_o(irq)
    );

    tcu_rdmux #(.CNT_W(CNT_W), .TVAL_W(TVAL_W)) u_rdmux (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .en(en), .mask(mask),
        .status(status), .cmp(cmp), .off(off), .remain(remain),
        .rd_data(reg_rdata)
    );

endmodule

// File: tb/test_gen_timer_cmp.sv
module test_gen_timer_cmp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_cnt = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq;

    typedef struct {
        bit          is_irq;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  smp_ev;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    always #2 clk = ~clk;

    gen_timer_cmp i_gen_timer_cmp (
        .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    // Monitor: pop the expected item and compare it with the output
    initial begin
        forever begin
            item_t it;
            logic [63:0] act;
            @(smp_ev);
            #1;
            it  = q.pop_front();
            act = it.is_irq ? {63'b0, irq} : reg_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk_rd(input logic [1:0] a, input logic [63:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        q.push_back('{is_irq: 1'b0, exp: e, tag: tag});
        -> smp_ev;
        #2;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        q.push_back('{is_irq: 1'b1, exp: {63'b0, e}, tag: tag});
        -> smp_ev;
        #2;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_rd(2'd0, 64'd0, "R1 ctrl");
        chk_rd(2'd1, 64'd0, "R1 cmp");
        chk_rd(2'd3, 64'd0, "R1 off");
        chk_irq(1'b0, "R1 irq");

        // R9 absolute write, R3 unsigned compare
        sys_cnt = 64'd1000;
        wr(2'd1, 64'h8000_0000_0000_0000);
        chk_rd(2'd1, 64'h8000_0000_0000_0000, "R9 cmp readback");
        wr(2'd0, 64'h1);
        chk_rd(2'd0, 64'h1, "R3 unsigned status");
        chk_irq(1'b0, "R3 unsigned irq");

        // R5 negative relative write fires at once; R6 read of -1
        wr(2'd2, 64'h1_FFFF_FFFF);
        chk_rd(2'd1, 64'd999, "R5 cmp");
        chk_rd(2'd0, 64'h5, "R5 status");
        chk_irq(1'b1, "R5 irq");
        chk_rd(2'd2, 64'h0000_0000_FFFF_FFFF, "R6 tval read");

        // R4 upper bits ignored
        wr(2'd2, 64'hABCD_0000_0000_0100);
        chk_rd(2'd1, 64'd1256, "R4 cmp");
        chk_rd(2'd2, 64'd256, "R2 tval read");
        chk_rd(2'd0, 64'h1, "R7 status low");
        chk_irq(1'b0, "R8 irq low");

        // R8 fires when the count reaches the deadline
        sys_cnt = 64'd1256;
        chk_rd(2'd0, 64'h5, "R7 status high");
        chk_irq(1'b1, "R8 irq high");

        // R8 mask
        wr(2'd0, 64'h3);
        chk_rd(2'd0, 64'h7, "R11 ctrl masked");
        chk_irq(1'b0, "R8 masked");

        // R7 writes to status ignored, disable clears status
        wr(2'd0, 64'h4);
        chk_rd(2'd0, 64'h0, "R7 disabled");
        chk_irq(1'b0, "R8 disabled");

        // R10 offset changes the virtual count
        wr(2'd0, 64'h1);
        wr(2'd3, 64'd500);
        chk_rd(2'd3, 64'd500, "R10 off readback");
        chk_rd(2'd2, 64'd500, "R10 tval with offset");
        chk_rd(2'd0, 64'h1, "R10 status");
        chk_irq(1'b0, "R10 irq");

        // R11 status bit is read-only while the condition is false
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFD);
        chk_rd(2'd0, 64'h1, "R11 ctrl write status bit");

        // R2 relative write with offset: deadline = (1256-500) + 10
        wr(2'd2, 64'd10);
        chk_rd(2'd1, 64'd766, "R2 cmp via vcnt");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule